// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a slow serial converter that signals "conversion finished" on its data-out line. When asked to start, it pulls chip select low and watches the converter's data-out line. While that line reads high the converter is still busy. Once the line reads low, the block generates a divided serial clock. It clocks in a 24-bit word, most significant bit first, and shifts channel-select bits out on its own data line. It then releases chip select and presents an 18-bit two's complement sample, over-range and under-range flags, and a framing check.

The sequencer has four states. `ST_IDLE` holds chip select high and the serial clock low. The transition *launch* (start seen) moves to `ST_POLL`. From `ST_POLL`, *ready* (data line low) moves to `ST_SHIFT`. *expire* (the poll limit is reached with the line still high) returns to `ST_IDLE` with a timeout pulse. *cancel* (abort) also returns to `ST_IDLE`. From `ST_SHIFT`, *complete* (the falling clock edge after the 24th rising edge) moves to `ST_DONE`, and *cancel* returns to `ST_IDLE` with no result. `ST_DONE` issues the result strobe and always takes *retire* back to `ST_IDLE`.

The serial clock spends `SCK_HALF` system cycles in each phase, and `SCK_HALF` must be at least 2. The number of channel bits is `CH_BITS`, and the poll limit is `POLL_LIMIT` cycles.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, and whenever no transfer is active, `cs_n` is 1 and `sck` and `sdi` are 0. `result_valid` and `timeout_err` are 0 after reset.
- R2: A `start` pulse in idle drives `cs_n` low on the next cycle. While `sdo_in` reads high in the poll state, `sck` stays low.
- R3: Once `sdo_in` is sampled low during polling, exactly 24 rising `sck` edges are produced. Each high phase lasts `SCK_HALF` cycles, and `sdo_in` is captured on each rising edge into a word whose first captured bit is bit 23.
- R4: `result` equals {NOT bit 21, bits 20..4} as an 18-bit two's complement number: with bit 21 set the value is bits 20..4, and with bit 21 clear it is bits 20..4 minus 131072. `over_range` is 1 when bits 21 and 20 are both 1. `under_range` is 1 when both are 0. The two flags are never set together.
- R5: `chan_sel` is captured at `start` and driven on `sdi` most significant bit first, one bit per rising `sck` edge, for the first `CH_BITS` edges. `sdi` then stays 0. `sdi` never changes while `sck` is high.
- R6: `result_valid` is high for exactly one cycle after a complete frame, in the cycle where `cs_n` has returned high. The result and flags hold their values until the next complete frame.
- R7: `frame_err` is set with the result when bit 23, bit 22 or any of bits 3..0 of the received word is 1, and is clear otherwise.
- R8: If `sdo_in` is still high on the `POLL_LIMIT`-th poll sample, `cs_n` goes high and `timeout_err` pulses for one cycle. `cs_n` has then been low for exactly `POLL_LIMIT` cycles, and no result is issued.
- R9: `abort` while `cs_n` is low drives `cs_n` high and `sck` low on the next cycle. No `result_valid` follows, and the previous result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a read (accepted in idle only) |
| abort | input | 1 | End the current read early |
| chan_sel | input | CH_BITS | Channel-select bits to send |
| sdo_in | input | 1 | Converter data out (busy flag, then frame) |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Channel-select data to the converter |
| result | output | 18 | Signed conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| over_range | output | 1 | Input above positive full scale |
| under_range | output | 1 | Input below negative full scale |
| frame_err | output | 1 | Fixed-zero bits of the frame were not zero |
| timeout_err | output | 1 | One-cycle pulse: busy flag never cleared |

## Verification
The hardest situation to reach from the ports is an abort that arrives at a chosen rising edge partway through a frame. A fixed delay cannot place it, because the number of poll cycles varies with the converter's busy time. The bench therefore models the converter and counts the rising edges it sees. It raises `abort` exactly when that count reaches 1, 12 or 23, and again during polling. The timeout case is reached by making the modelled conversion longer than the poll limit and counting the cycles for which chip select stays low.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_LEN = 24;
    localparam int RES_W     = 18;
    localparam int EOC_POS   = 23;
    localparam int ZERO_POS  = 22;
    localparam int SIGN_POS  = 21;
    localparam int MSB_POS   = 20;
    localparam int LSB_POS   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic [RES_W-1:0] value;
        logic             over;
        logic             under;
        logic             bad_frame;
    } decode_t;

endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic sck,
    output logic rise_evt,
    output logic fall_evt
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] PHASE_LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == PHASE_LAST);
    assign rise_evt = en && wrap && !sck;
    assign fall_evt = en && wrap && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (!en || clr) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_frame_decode.sv
module adc_frame_decode
    import adc_rd_pkg::*;
(
    input  logic [FRAME_LEN-1:0] frame,
    output decode_t              dec
);

    logic [LSB_POS-1:0] tail;

    assign tail = frame[LSB_POS-1:0];

    always_comb begin
        dec.value     = {~frame[SIGN_POS], frame[MSB_POS:LSB_POS]};
        dec.over      = frame[SIGN_POS] & frame[MSB_POS];
        dec.under     = ~frame[SIGN_POS] & ~frame[MSB_POS];
        dec.bad_frame = frame[EOC_POS] | frame[ZERO_POS] | (|tail);
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int SCK_HALF   = 4,
    parameter int CH_BITS    = 8,
    parameter int POLL_LIMIT = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic [CH_BITS-1:0] chan_sel,
    input  logic               sdo_in,
    output logic               cs_n,
    output logic               sck,
    output logic               sdi,
    output logic [RES_W-1:0]   result,
    output logic               result_valid,
    output logic               over_range,
    output logic               under_range,
    output logic               frame_err,
    output logic               timeout_err
);

    localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam int BCW = $clog2(FRAME_LEN + 1);
    localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_LIMIT - 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(FRAME_LEN);

    rd_state_e              state;
    rd_state_e              nxt;
    logic [PCW-1:0]         poll_cnt;
    logic [BCW-1:0]         bit_cnt;
    logic [FRAME_LEN-1:0]   frame_sr;
    logic [CH_BITS-1:0]     chan_sr;
    logic                   sck_rise;
    logic                   sck_fall;
    logic                   sck_run;
    logic                   poll_expired;
    logic                   frame_end;
    decode_t                dec;

    assign sck_run      = (state == ST_SHIFT);
    assign poll_expired = (state == ST_POLL) && sdo_in && (poll_cnt == POLL_LAST);
    assign frame_end    = (state == ST_SHIFT) && sck_fall && (bit_cnt == BIT_LAST);
    assign sdi          = sck_run && chan_sr[CH_BITS-1];

    adc_sck_gen #(
        .HALF (SCK_HALF)
    ) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sck_run),
        .clr      (abort),
        .sck      (sck),
        .rise_evt (sck_rise),
        .fall_evt (sck_fall)
    );

    adc_frame_decode u_dec (
        .frame (frame_sr),
        .dec   (dec)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_POLL;
            end
            ST_POLL: begin
                if (abort)             nxt = ST_IDLE;
                else if (!sdo_in)      nxt = ST_SHIFT;
                else if (poll_expired) nxt = ST_IDLE;
            end
            ST_SHIFT: begin
                if (abort)          nxt = ST_IDLE;
                else if (frame_end) nxt = ST_DONE;
            end
            ST_DONE: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // counters and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            bit_cnt  <= '0;
            frame_sr <= '0;
            chan_sr  <= '0;
        end else begin
            if (state == ST_POLL) poll_cnt <= poll_cnt + 1'b1;
            else                  poll_cnt <= '0;

            if (state != ST_SHIFT) bit_cnt <= '0;
            else if (sck_rise)     bit_cnt <= bit_cnt + 1'b1;

            if (sck_rise) frame_sr <= {frame_sr[FRAME_LEN-2:0], sdo_in};

            if (state == ST_IDLE && start)
                chan_sr <= chan_sel;
            else if (state == ST_SHIFT && sck_fall)
                chan_sr <= chan_sr << 1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n         <= 1'b1;
            result       <= '0;
            result_valid <= 1'b0;
            over_range   <= 1'b0;
            under_range  <= 1'b0;
            frame_err    <= 1'b0;
            timeout_err  <= 1'b0;
        end else begin
            cs_n         <= !(nxt == ST_POLL || nxt == ST_SHIFT);
            result_valid <= (nxt == ST_DONE) && (state == ST_SHIFT);
            timeout_err  <= poll_expired && !abort;
            if (nxt == ST_DONE && state == ST_SHIFT) begin
                result      <= dec.value;
                over_range  <= dec.over;
                under_range <= dec.under;
                frame_err   <= dec.bad_frame;
            end
        end
    end

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic cs_n,
    input logic sck,
    input logic sdi,
    input logic result_valid,
    input logic over_range,
    input logic under_range,
    input logic timeout_err
);

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R1

    AST_IDLE_SDI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdi); // R1

    AST_SDI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck && $past(sck)) |-> $stable(sdi)); // R5

    AST_RANGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !(over_range && under_range)); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6

    AST_VALID_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cs_n); // R6

    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (cs_n && !result_valid)); // R8

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !cs_n) |=> (cs_n && !sck && !result_valid)); // R9

endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort        (abort),
    .cs_n         (cs_n),
    .sck          (sck),
    .sdi          (sdi),
    .result_valid (result_valid),
    .over_range   (over_range),
    .under_range  (under_range),
    .timeout_err  (timeout_err)
);

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;

    localparam int HALF  = 2;
    localparam int CH    = 8;
    localparam int LIMIT = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [CH-1:0] chan_sel = '0;
    logic          sdo_in;
    logic          cs_n;
    logic          sck;
    logic          sdi;
    logic [17:0]   result;
    logic          result_valid;
    logic          over_range;
    logic          under_range;
    logic          frame_err;
    logic          timeout_err;

    int total = 0;
    int bad   = 0;

    // converter model configuration
    logic [23:0] cfg_frame = '0;
    int          cfg_busy  = 0;
    logic        cfg_load  = 1'b0;

    // converter model state
    int          m_busy    = 0;
    int          m_ptr     = 23;
    int          m_rises   = 0;
    int          hi_run    = 0;
    int          hi_bad    = 0;
    int          busy_rise = 0;
    int          sdi_extra = 0;
    logic [CH-1:0] m_chan  = '0;
    logic        sck_d     = 1'b0;
    logic        cs_d      = 1'b1;

    always #5 clk = ~clk;

    adc_frame_reader #(
        .SCK_HALF   (HALF),
        .CH_BITS    (CH),
        .POLL_LIMIT (LIMIT)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .abort        (abort),
        .chan_sel     (chan_sel),
        .sdo_in       (sdo_in),
        .cs_n         (cs_n),
        .sck          (sck),
        .sdi          (sdi),
        .result       (result),
        .result_valid (result_valid),
        .over_range   (over_range),
        .under_range  (under_range),
        .frame_err    (frame_err),
        .timeout_err  (timeout_err)
    );

    assign sdo_in = cs_n ? 1'b1 :
                    (m_busy != 0) ? 1'b1 :
                    (m_ptr >= 0) ? cfg_frame[m_ptr[4:0]] : 1'b0;

    always @(posedge clk) begin
        sck_d <= sck;
        cs_d  <= cs_n;
        if (cfg_load) m_busy <= cfg_busy;
        else if (m_busy != 0) m_busy <= m_busy - 1;

        if (cfg_load) begin
            hi_bad    <= 0;
            busy_rise <= 0;
            sdi_extra <= 0;
            m_chan    <= '0;
        end else begin
            if (sck) hi_run <= hi_run + 1;
            else begin
                if (hi_run != 0 && hi_run != HALF) hi_bad <= hi_bad + 1;
                hi_run <= 0;
            end
            if (!cs_n && !sck_d && sck) begin
                if (m_rises < CH) m_chan <= {m_chan[CH-2:0], sdi};
                else if (sdi) sdi_extra <= sdi_extra + 1;
                if (m_busy != 0) busy_rise <= busy_rise + 1;
            end
        end

        if (!cs_d && cs_n) begin
            m_ptr   <= 23;
            m_rises <= 0;
        end else if (!cs_n) begin
            if (sck_d && !sck) m_ptr <= m_ptr - 1;
            if (!sck_d && sck) m_rises <= m_rises + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [23:0] f, input int busy, input logic [CH-1:0] ch);
        @(negedge clk);
        cfg_frame = f;
        cfg_busy  = busy;
        cfg_load  = 1'b1;
        chan_sel  = ch;
        start     = 1'b1;
        @(negedge clk);
        cfg_load  = 1'b0;
        start     = 1'b0;
        chan_sel  = ~ch;
        chk(cs_n == 1'b0, "R2", "cs_n after start", cs_n, 0);
        chk(sck == 1'b0, "R2", "sck while polling", sck, 0);
    endtask

    task automatic run_frame(input logic sg, input logic [16:0] mag, input logic dmy,
                             input logic [3:0] tail, input logic [CH-1:0] ch, input int busy);
        logic [23:0] f;
        bit          got;
        longint      exp_val;
        got = 1'b0;
        f = {1'b0, dmy, sg, mag, tail};
        launch(f, busy, ch);
        for (int i = 0; i < 3000 && !got; i++) begin
            if (result_valid) got = 1'b1;
            else @(negedge clk);
        end
        chk(got, "R6", "result_valid seen", got, 1);
        if (got) begin
            exp_val = sg ? longint'(mag) : longint'(mag) - 131072;
            chk($signed(result) == exp_val, "R4", "result value", $signed(result), exp_val);
            chk(over_range == (sg & mag[16]), "R4", "over_range", over_range, sg & mag[16]);
            chk(under_range == (!sg & !mag[16]), "R4", "under_range", under_range, !sg & !mag[16]);
            chk(frame_err == (dmy | (|tail)), "R7", "frame_err", frame_err, dmy | (|tail));
            chk(cs_n == 1'b1, "R6", "cs_n with valid", cs_n, 1);
            chk(m_rises == 24, "R3", "rising edges", m_rises, 24);
            chk(hi_bad == 0, "R3", "high phase width errors", hi_bad, 0);
            chk(busy_rise == 0, "R2", "sck edges while busy", busy_rise, 0);
            chk(m_chan == ch, "R5", "channel bits", m_chan, ch);
            chk(sdi_extra == 0, "R5", "sdi after channel bits", sdi_extra, 0);
            @(negedge clk);
            chk(result_valid == 1'b0, "R6", "valid width", result_valid, 0);
            @(negedge clk);
            chk(cs_n && !sck && !sdi, "R1", "idle lines", {cs_n, sck, sdi}, 3'b100);
        end
    endtask

    task automatic run_abort(input int at_rise, input int busy);
        logic [17:0] prev;
        bit          seen;
        prev = result;
        seen = 1'b0;
        launch(24'h2A5A50, busy, 8'h5C);
        if (at_rise == 0) begin
            repeat (10) @(negedge clk);
        end else begin
            for (int i = 0; i < 2000 && m_rises != at_rise; i++) @(negedge clk);
        end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(cs_n == 1'b1, "R9", "cs_n after abort", cs_n, 1);
        chk(sck == 1'b0, "R9", "sck after abort", sck, 0);
        for (int i = 0; i < 40; i++) begin
            if (result_valid || timeout_err) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R9", "no result after abort", seen, 0);
        chk(result == prev, "R9", "result kept", result, prev);
    endtask

    task automatic run_timeout();
        logic [17:0] prev;
        int          low_cnt;
        bit          got;
        prev    = result;
        low_cnt = 0;
        got     = 1'b0;
        @(negedge clk);
        cfg_frame = 24'h200000;
        cfg_busy  = LIMIT + 400;
        cfg_load  = 1'b1;
        start     = 1'b1;
        @(negedge clk);
        cfg_load  = 1'b0;
        start     = 1'b0;
        for (int i = 0; i < 2000 && !got; i++) begin
            if (timeout_err) got = 1'b1;
            else begin
                if (!cs_n) low_cnt++;
                @(negedge clk);
            end
        end
        chk(got, "R8", "timeout pulse", got, 1);
        chk(low_cnt == LIMIT, "R8", "cs_n low cycles", low_cnt, LIMIT);
        chk(cs_n == 1'b1, "R8", "cs_n at timeout", cs_n, 1);
        @(negedge clk);
        chk(timeout_err == 1'b0, "R8", "timeout pulse width", timeout_err, 0);
        chk(result == prev && !result_valid, "R8", "no result on timeout", result, prev);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        chk(sck == 1'b0 && sdi == 1'b0, "R1", "sck/sdi in reset", {sck, sdi}, 0);
        chk(result_valid == 1'b0 && timeout_err == 1'b0, "R1", "strobes in reset",
            {result_valid, timeout_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R1", "idle after reset", {cs_n, sck}, 2);

        // walking one through the 17 result bits, alternating sign
        for (int i = 0; i < 17; i++) begin
            run_frame(1'(i % 2), 17'(1 << i), 1'b0, 4'h0, CH'(i * 37 + 5), (i % 5) * 7);
        end
        // full-scale and zero corners on both signs
        run_frame(1'b1, 17'h1FFFF, 1'b0, 4'h0, 8'hFF, 3);
        run_frame(1'b0, 17'h1FFFF, 1'b0, 4'h0, 8'h00, 0);
        run_frame(1'b1, 17'h00000, 1'b0, 4'h0, 8'h81, 12);
        run_frame(1'b0, 17'h00000, 1'b0, 4'h0, 8'h7E, 5);
        run_frame(1'b1, 17'h0FFFF, 1'b0, 4'h0, 8'hA5, 9);
        // framing errors
        run_frame(1'b1, 17'h12345, 1'b1, 4'h0, 8'h3C, 4);
        run_frame(1'b0, 17'h0ABCD, 1'b0, 4'h1, 8'hC3, 4);
        run_frame(1'b1, 17'h05555, 1'b0, 4'h8, 8'h96, 4);
        run_frame(1'b1, 17'h05555, 1'b0, 4'h0, 8'h69, 4);

        // aborts during polling and at chosen rising edges
        run_abort(0, 30);
        run_abort(1, 3);
        run_abort(12, 3);
        run_abort(23, 3);

        run_timeout();

        // a clean frame after the error paths
        run_frame(1'b0, 17'h1F000, 1'b0, 4'h0, 8'h42, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule